// File: doc/BRIEF.md
# Multi-Mode Constellation Mapper with Normalization

This block turns a serial bit stream into complex constellation points for a multicarrier transmitter. Bits enter one at a time with a qualifier. They are gathered into symbols whose size depends on the selected modulation. Each finished symbol produces one signed 16-bit I/Q pair with 14 fractional bits. Four modulations are available: QPSK, uniform 16-QAM, and hierarchical 16-QAM with alpha 2 and with alpha 4.

Each modulation has its own power normalization. The normalization is folded into the stored amplitude levels, so a downstream stage can use the pair directly without a multiplier. The mode select is taken when the first bit of a symbol arrives. The bits that follow belong to that symbol, whatever the mode input does in the meantime.

Top module: `qam_mapper`

## Requirements
- R1: While reset is asserted and after it is released, valid_o is 0 and i_o and q_o are 0 until the first symbol completes.
- R2: The mode select is encoded as 0 = QPSK, 1 = uniform 16-QAM, 2 = hierarchical 16-QAM with alpha 2, and 3 = hierarchical 16-QAM with alpha 4. A QPSK symbol takes 2 qualified bits and every other mode takes 4. Each completed symbol gives exactly one output pulse.
- R3: valid_o is high for exactly one cycle, in the cycle after the clock edge that accepts the last bit of a symbol. i_o and q_o keep their value until the next symbol completes.
- R4: The first bit of a symbol sets the sign of I and the second bit sets the sign of Q. A bit value of 0 gives a positive component and 1 gives a negative one.
- R5: In the 16-QAM modes, the third bit chooses the I magnitude and the fourth bit chooses the Q magnitude. A value of 0 selects the inner level and 1 selects the outer level.
- R6: In QPSK, both magnitudes are round(16384/sqrt(2)) = 11585.
- R7: In uniform 16-QAM, the magnitudes are round(16384*{1,3}/sqrt(10)) = 5181 and 15543.
- R8: With alpha 2, the magnitudes are round(16384*{2,4}/sqrt(20)) = 7327 and 14654.
- R9: With alpha 4, the magnitudes are round(16384*{4,6}/sqrt(52)) = 9088 and 13632.
- R10: The mode select is sampled only with the first bit of a symbol. A change of mode_i during the rest of the symbol has no effect on that symbol's bit count or its levels.
- R11: A cycle with bit_valid_i low leaves the symbol in progress and the outputs unchanged, whatever value bit_i has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial data bit |
| bit_valid_i | input | 1 | Qualifies bit_i |
| mode_i | input | 2 | Modulation select |
| i_o | output | 16 | In-phase component, signed, 14 fractional bits |
| q_o | output | 16 | Quadrature component, signed, 14 fractional bits |
| valid_o | output | 1 | One-cycle pulse marking a new I/Q pair |

## Verification
The bench sweeps every bit pattern of every mode. It checks each level against a value that it works out with square roots and rounding.

A mix-up of the sign bits and the level bits, or an inverted inner/outer choice, shows up as a wrong component. A wrong table entry shows up in the mode that uses it.

Every symbol after its first bit is driven with a different mode value on mode_i. A design that reads the mode continuously would then count the wrong number of bits, or pick levels from the wrong table. Idle cycles with bit_i toggling are placed between bits. A collector that ignored the qualifier would complete symbols early. The bench also checks that the outputs hold steady between pulses.

// File: rtl/ofdm_map_pkg.sv
package ofdm_map_pkg;
  localparam int SAMPLE_W = 16;
  localparam int MAX_BITS = 4;

  typedef enum logic [1:0] {
    MODE_QPSK    = 2'd0,
    MODE_QAM16   = 2'd1,
    MODE_HIER_A2 = 2'd2,
    MODE_HIER_A4 = 2'd3
  } map_mode_e;

  // levels pre-scaled by the mode's normalization, Q1.14
  localparam logic [SAMPLE_W-1:0] LVL_QPSK     = 16'd11585;
  localparam logic [SAMPLE_W-1:0] LVL_QAM16_IN = 16'd5181;
  localparam logic [SAMPLE_W-1:0] LVL_QAM16_OU = 16'd15543;
  localparam logic [SAMPLE_W-1:0] LVL_A2_IN    = 16'd7327;
  localparam logic [SAMPLE_W-1:0] LVL_A2_OU    = 16'd14654;
  localparam logic [SAMPLE_W-1:0] LVL_A4_IN    = 16'd9088;
  localparam logic [SAMPLE_W-1:0] LVL_A4_OU    = 16'd13632;

  function automatic int bits_per_sym(map_mode_e m);
    return (m == MODE_QPSK) ? 2 : 4;
  endfunction
endpackage

// File: rtl/map_bit_gather.sv
module map_bit_gather
  import ofdm_map_pkg::*;
#(
  parameter int NBITS = MAX_BITS,
  localparam int CNT_W = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  input  map_mode_e        mode_i,
  output logic             done_o,
  output logic [NBITS-1:0] word_o,
  output map_mode_e        mode_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [NBITS-1:0] word_q, word_next;
  map_mode_e        mode_q, eff_mode;
  logic [CNT_W-1:0] last_idx;

  // mode is taken from the port only on the first bit of a symbol
  assign eff_mode = (cnt_q == '0) ? mode_i : mode_q;
  assign last_idx = CNT_W'(bits_per_sym(eff_mode) - 1);

  always_comb begin
    word_next = word_q;
    if (bit_valid_i) word_next[cnt_q] = bit_i;
  end

  assign done_o = bit_valid_i && (cnt_q == last_idx);
  assign word_o = word_next;
  assign mode_o = eff_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_q <= '0;
      mode_q <= MODE_QPSK;
    end else if (bit_valid_i) begin
      mode_q <= eff_mode;
      word_q <= done_o ? '0 : word_next;
      cnt_q  <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R2
  // cnt_in_range_chk
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (int'(cnt_q) < bits_per_sym(mode_q)));

  // R10
  // mode_held_chk
  mode_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && $past(cnt_q) != '0) |-> $stable(mode_q));
endmodule

// File: rtl/map_level_lut.sv
module map_level_lut
  import ofdm_map_pkg::*;
(
  input  map_mode_e           mode_i,
  input  logic                outer_i,
  output logic [SAMPLE_W-1:0] mag_o
);
  always_comb begin
    unique case (mode_i)
      MODE_QPSK:    mag_o = LVL_QPSK;
      MODE_QAM16:   mag_o = outer_i ? LVL_QAM16_OU : LVL_QAM16_IN;
      MODE_HIER_A2: mag_o = outer_i ? LVL_A2_OU    : LVL_A2_IN;
      MODE_HIER_A4: mag_o = outer_i ? LVL_A4_OU    : LVL_A4_IN;
      default:      mag_o = '0;
    endcase
  end
endmodule

// File: rtl/qam_mapper.sv
module qam_mapper
  import ofdm_map_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_i,
  input  logic        bit_valid_i,
  input  logic [1:0]  mode_i,
  output logic [15:0] i_o,
  output logic [15:0] q_o,
  output logic        valid_o
);
  localparam int NAXES = 2;

  logic                 done;
  logic [MAX_BITS-1:0]  word;
  map_mode_e            sym_mode;
  logic signed [SAMPLE_W-1:0] axis_val [NAXES];
  logic signed [SAMPLE_W-1:0] axis_q   [NAXES];
  logic                 valid_q;
  map_mode_e            out_mode_q;

  map_bit_gather #(.NBITS(MAX_BITS)) u_gather (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .mode_i      (map_mode_e'(mode_i)),
    .done_o      (done),
    .word_o      (word),
    .mode_o      (sym_mode)
  );

  // axis a: sign from bit a, inner/outer from bit a+2
  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    logic [SAMPLE_W-1:0] mag;
    map_level_lut u_lut (
      .mode_i  (sym_mode),
      .outer_i (word[a+NAXES]),
      .mag_o   (mag)
    );
    assign axis_val[a] = word[a] ? -$signed(mag) : $signed(mag);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      axis_q[0]  <= '0;
      axis_q[1]  <= '0;
      valid_q    <= 1'b0;
      out_mode_q <= MODE_QPSK;
    end else begin
      valid_q <= done;
      if (done) begin
        axis_q[0]  <= axis_val[0];
        axis_q[1]  <= axis_val[1];
        out_mode_q <= sym_mode;
      end
    end
  end

  assign i_o     = axis_q[0];
  assign q_o     = axis_q[1];
  assign valid_o = valid_q;

  // R3
  // valid_after_bit_chk
  valid_after_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_valid_i));

  // R3
  // single_pulse_chk
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R3
  // hold_chk
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_o) && $stable(q_o)));

  // R6
  // qpsk_level_chk
  qpsk_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && out_mode_q == MODE_QPSK) |->
      ((i_o == LVL_QPSK || i_o == 16'(-$signed(LVL_QPSK))) &&
       (q_o == LVL_QPSK || q_o == 16'(-$signed(LVL_QPSK)))));

  // R5
  // nonzero_chk
  nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (i_o != '0 && q_o != '0));
endmodule

// File: tb/qam_mapper_tb_top.sv
`timescale 1ns/1ps
module qam_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic        bit_vld = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] i_out, q_out;
  logic        vld_out;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  qam_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_valid_i(bit_vld),
    .mode_i(mode), .i_o(i_out), .q_o(q_out), .valid_o(vld_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  function automatic int expect_mag(int m, int outer);
    real lvl, norm;
    case (m)
      0: begin lvl = 1.0; norm = 2.0; end
      1: begin lvl = outer ? 3.0 : 1.0; norm = 10.0; end
      2: begin lvl = outer ? 4.0 : 2.0; norm = 20.0; end
      default: begin lvl = outer ? 6.0 : 4.0; norm = 52.0; end
    endcase
    return $rtoi(lvl * 16384.0 / $sqrt(norm) + 0.5);
  endfunction

  // sends one symbol; mode_i is changed after the first bit (R10)
  task automatic send_symbol(int m, int pattern, int gap);
    int nb = (m == 0) ? 2 : 4;
    int ei, eq;
    logic [15:0] hi, hq;
    for (int k = 0; k < nb; k++) begin
      mode = (k == 0) ? 2'(m) : 2'((m + 1 + k) % 4);
      bit_in = pattern[k];
      bit_vld = 1'b1;
      @(negedge clk);
      if (k < nb - 1) begin
        check("R2 early valid", 32'(vld_out), 32'd0);
        hi = i_out; hq = q_out;
        for (int g = 0; g < gap; g++) begin
          bit_vld = 1'b0;
          bit_in = ~bit_in;
          @(negedge clk);
          check("R11 idle valid", 32'(vld_out), 32'd0);
          check("R11 idle hold", {i_out, q_out}, {hi, hq});
        end
      end
    end
    bit_vld = 1'b0;
    check("R3 valid pulse", 32'(vld_out), 32'd1);
    ei = expect_mag(m, (m == 0) ? 0 : pattern[2]);
    eq = expect_mag(m, (m == 0) ? 0 : pattern[3]);
    if (pattern[0]) ei = -ei;
    if (pattern[1]) eq = -eq;
    case (m)
      0: begin check("R6 R4 I", 32'($signed(i_out)), 32'(ei)); check("R6 R4 Q", 32'($signed(q_out)), 32'(eq)); end
      1: begin check("R7 R5 I", 32'($signed(i_out)), 32'(ei)); check("R7 R5 Q", 32'($signed(q_out)), 32'(eq)); end
      2: begin check("R8 R5 I", 32'($signed(i_out)), 32'(ei)); check("R8 R5 Q", 32'($signed(q_out)), 32'(eq)); end
      default: begin check("R9 R5 I", 32'($signed(i_out)), 32'(ei)); check("R9 R5 Q", 32'($signed(q_out)), 32'(eq)); end
    endcase
    hi = i_out; hq = q_out;
    @(negedge clk);
    check("R3 pulse width", 32'(vld_out), 32'd0);
    check("R3 hold", {i_out, q_out}, {hi, hq});
  endtask

  initial begin
    @(negedge clk);
    check("R1 reset valid", 32'(vld_out), 32'd0);
    check("R1 reset data", {i_out, q_out}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset", {15'd0, vld_out, i_out, q_out}, 32'd0);
    for (int m = 0; m < 4; m++) begin
      int npat = (m == 0) ? 4 : 16;
      for (int p = 0; p < npat; p++) send_symbol(m, p, p % 3);
    end
    // back-to-back symbols across modes (R2 R10)
    for (int r = 0; r < 8; r++) send_symbol(r % 4, (r * 5) % 16, 0);
    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule